// File: doc/BRIEF.md
# Transmit Retry and Forced-Collision Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC. It tracks the attempts made for one frame. It pulses a strobe at the start of each attempt. After a collision it waits a pseudo-random number of slot times before the next attempt, with a truncated binary exponential range. When no attempts remain, it reports that the frame failed. A transmit that completes without a collision gives a success pulse.

The attempt limit has two settings, chosen by a disable-retry bit. The bit is sampled only when an initialization strobe arrives while the block is idle:

- With the bit set, one attempt is made.
- With the bit clear, up to `ATTEMPT_LIMIT` attempts are made (16 by default).

A test input forces a collision on every attempt, so that the failure path can be exercised. It acts only while the loopback mode selects an internal loopback.

Top module: `tx_retry_ctrl`

## Requirements
- R1: During and after reset, with no stimulus, `attempt_go`, `frame_ok` and `retry_err` stay low.
- R2: `frame_start` sampled high drives `attempt_go` high in the next cycle for exactly one cycle, and this starts attempt number 1.
- R3: During an attempt, `tx_done` without a collision pulses `frame_ok` for one cycle in the next cycle. The block then goes back to idle.
- R4: After a collision on attempt k that is not the last one, the block picks a slot count s in the range [0, 2^min(k,BACKOFF_CAP) - 1]. The next `attempt_go` appears s*SLOT_CYCLES + 2 cycles after the collision cycle.
- R5: With disable-retry captured as 0, the collision on attempt `ATTEMPT_LIMIT` pulses `retry_err` for one cycle in the next cycle. No further attempt follows, and the block returns to idle.
- R6: With disable-retry captured as 1, the first collision pulses `retry_err` in the next cycle.
- R7: `cfg_no_retry` is captured only on a cycle where `init_load` is high and the block is idle. Changes at other times have no effect on the attempt limit.
- R8: When `cfg_force_coll` is 1 and `loop_mode[1]` is 1 (10 = internal loopback with encoder, 11 = internal loopback without encoder), every attempt collides in its first cycle, with no `coll_det` needed. The frame therefore always ends in `retry_err`.
- R9: When `loop_mode` is 00 (no loopback) or 01 (external loopback), `cfg_force_coll` is ignored and frames finish normally.
- R10: When `coll_det` and `tx_done` arrive in the same attempt cycle, the collision wins: there is no `frame_ok`, and a backoff and a new attempt follow.
- R11: `frame_start` during a frame restarts it. The next attempt is numbered 1, so a full `ATTEMPT_LIMIT` collisions are again needed for `retry_err`.
- R12: `coll_det`, `tx_done` and a forced collision are ignored while no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_load | input | 1 | Initialization strobe that captures `cfg_no_retry` (taken only while idle) |
| cfg_no_retry | input | 1 | Disable-retry value offered at initialization |
| cfg_force_coll | input | 1 | Collision injection request for test |
| loop_mode | input | 2 | 00 none, 01 external, 10 internal with encoder, 11 internal without encoder |
| frame_start | input | 1 | Start (or restart) of a frame |
| coll_det | input | 1 | Collision seen on the medium |
| tx_done | input | 1 | Transmission of the current attempt completed |
| attempt_go | output | 1 | One-cycle strobe at the start of each attempt |
| frame_ok | output | 1 | One-cycle success pulse |
| retry_err | output | 1 | One-cycle retry-error pulse |

## Verification
The bench builds the block with `ATTEMPT_LIMIT`=16, `SLOT_CYCLES`=4 and `BACKOFF_CAP`=4. The full 16-attempt path then takes about a thousand cycles. These values also bring the backoff cap into reach: from the fourth collision on, the slot range stops growing.

The bench sweeps every collision count from 0 to 15 before a successful completion, and runs all four loopback modes with injection on. For each backoff gap, it works out from the collision index whether the gap is a whole number of slots within the allowed range.

// File: rtl/tx_retry_pkg.sv
package tx_retry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_WAIT = 2'd2
    } tx_state_e;

    // loop_mode[1] set selects one of the two internal loopback variants
    function automatic logic loop_is_internal(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/retry_lfsr.sv
module retry_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign rnd = state_q;

endmodule

// File: rtl/backoff_range.sv
module backoff_range #(
    parameter int RND_W  = 16,
    parameter int SLOT_W = 10,
    parameter int CNT_W  = 5
) (
    input  logic [RND_W-1:0]  rnd,
    input  logic [CNT_W-1:0]  attempt,
    output logic [SLOT_W-1:0] slots
);

    logic [SLOT_W-1:0] mask;
    logic [SLOT_W-1:0] folded;

    // bit i is allowed when i < min(attempt, SLOT_W)
    for (genvar i = 0; i < SLOT_W; i++) begin : g_mask
        assign mask[i] = (32'(attempt) > i);
    end

    assign folded = rnd[SLOT_W-1:0] ^ rnd[RND_W-1 -: SLOT_W];
    assign slots  = folded & mask;

endmodule

// File: rtl/backoff_timer.sv
module backoff_timer #(
    parameter int SLOT_W      = 10,
    parameter int SLOT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [SLOT_W-1:0] slots_in,
    output logic              expire
);

    localparam int CYC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CYC_W-1:0] CYC_TOP = CYC_W'(SLOT_CYCLES - 1);

    typedef struct packed {
        logic              run;
        logic [SLOT_W-1:0] slots;
        logic [CYC_W-1:0]  cyc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = tmr_q.run && (tmr_q.slots == '0);
        if (clear) begin
            tmr_d.run = 1'b0;
        end else if (load) begin
            tmr_d.run   = 1'b1;
            tmr_d.slots = slots_in;
            tmr_d.cyc   = CYC_TOP;
        end else if (tmr_q.run) begin
            if (tmr_q.slots == '0) begin
                tmr_d.run = 1'b0;
            end else if (tmr_q.cyc == '0) begin
                tmr_d.slots = tmr_q.slots - 1'b1;
                tmr_d.cyc   = CYC_TOP;
            end else begin
                tmr_d.cyc = tmr_q.cyc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/tx_retry_ctrl.sv
module tx_retry_ctrl
    import tx_retry_pkg::*;
#(
    parameter int ATTEMPT_LIMIT = 16,
    parameter int SLOT_CYCLES   = 64,
    parameter int BACKOFF_CAP   = 10,
    parameter int RND_W         = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_load,
    input  logic       cfg_no_retry,
    input  logic       cfg_force_coll,
    input  logic [1:0] loop_mode,
    input  logic       frame_start,
    input  logic       coll_det,
    input  logic       tx_done,
    output logic       attempt_go,
    output logic       frame_ok,
    output logic       retry_err
);

    localparam int CNT_W = $clog2(ATTEMPT_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_FULL = CNT_W'(ATTEMPT_LIMIT);
    localparam logic [CNT_W-1:0] LIMIT_ONE  = CNT_W'(1);

    typedef struct packed {
        tx_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             no_retry;
        logic             attempt;
        logic             ok;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [RND_W-1:0]       rnd;
    logic [BACKOFF_CAP-1:0] slots;
    logic                   tmr_load;
    logic                   tmr_clear;
    logic                   tmr_expire;
    logic                   force_eff;
    logic                   collided;
    logic [CNT_W-1:0]       limit;

    retry_lfsr #(.W(RND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    backoff_range #(
        .RND_W  (RND_W),
        .SLOT_W (BACKOFF_CAP),
        .CNT_W  (CNT_W)
    ) u_range (
        .rnd     (rnd),
        .attempt (ctl_q.cnt),
        .slots   (slots)
    );

    backoff_timer #(
        .SLOT_W      (BACKOFF_CAP),
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .clear    (tmr_clear),
        .slots_in (slots),
        .expire   (tmr_expire)
    );

    assign force_eff = cfg_force_coll && loop_is_internal(loop_mode);
    assign collided  = coll_det || force_eff;
    assign limit     = ctl_q.no_retry ? LIMIT_ONE : LIMIT_FULL;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.attempt = 1'b0;
        ctl_d.ok      = 1'b0;
        ctl_d.err     = 1'b0;
        tmr_load      = 1'b0;
        tmr_clear     = 1'b0;

        if (init_load && ctl_q.state == ST_IDLE) begin
            ctl_d.no_retry = cfg_no_retry;
        end

        if (frame_start) begin
            ctl_d.state   = ST_TX;
            ctl_d.cnt     = LIMIT_ONE;
            ctl_d.attempt = 1'b1;
            tmr_clear     = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_TX: begin
                    if (collided) begin
                        if (ctl_q.cnt >= limit) begin
                            ctl_d.err   = 1'b1;
                            ctl_d.state = ST_IDLE;
                            ctl_d.cnt   = '0;
                        end else begin
                            ctl_d.state = ST_WAIT;
                            tmr_load    = 1'b1;
                        end
                    end else if (tx_done) begin
                        ctl_d.ok    = 1'b1;
                        ctl_d.state = ST_IDLE;
                        ctl_d.cnt   = '0;
                    end
                end
                ST_WAIT: begin
                    if (tmr_expire) begin
                        ctl_d.state   = ST_TX;
                        ctl_d.cnt     = ctl_q.cnt + 1'b1;
                        ctl_d.attempt = 1'b1;
                    end
                end
                default: begin
                    ctl_d.state = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign attempt_go = ctl_q.attempt;
    assign frame_ok   = ctl_q.ok;
    assign retry_err  = ctl_q.err;

endmodule

// File: rtl/tx_retry_chk.sv
module tx_retry_chk
    import tx_retry_pkg::*;
#(
    parameter int ATTEMPT_LIMIT = 16,
    parameter int CNT_W         = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             cfg_force_coll,
    input logic [1:0]       loop_mode,
    input logic             attempt_go,
    input logic             frame_ok,
    input logic             retry_err,
    input tx_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic             no_retry_q
);

    a_r1_r3_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && retry_err));

    a_r2_attempt_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> attempt_go);

    a_r3_ok_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);

    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ATTEMPT_LIMIT));

    a_r5_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |=> !retry_err);

    a_r5_err_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        retry_err |-> ($past(cnt_q) == ($past(no_retry_q) ? CNT_W'(1) : CNT_W'(ATTEMPT_LIMIT))));

    a_r6_single_attempt: assert property (@(posedge clk) disable iff (!rst_n)
        (no_retry_q && attempt_go) |-> (cnt_q == CNT_W'(1)));

    a_r7_cfg_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(no_retry_q));

    a_r8_forced_never_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_force_coll && loop_mode[1] && state_q == ST_TX && !frame_start) |=> !frame_ok);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_start) |=> (!attempt_go && !frame_ok && !retry_err));

endmodule

bind tx_retry_ctrl tx_retry_chk #(
    .ATTEMPT_LIMIT (ATTEMPT_LIMIT),
    .CNT_W         (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .cfg_force_coll (cfg_force_coll),
    .loop_mode      (loop_mode),
    .attempt_go     (attempt_go),
    .frame_ok       (frame_ok),
    .retry_err      (retry_err),
    .state_q        (ctl_q.state),
    .cnt_q          (ctl_q.cnt),
    .no_retry_q     (ctl_q.no_retry)
);

// File: tb/tx_retry_ctrl_test.sv
module tx_retry_ctrl_test;

    localparam int CLK_P = 10;
    localparam int LIM   = 16;
    localparam int SC    = 4;
    localparam int CAP   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_load = 1'b0;
    logic       cfg_no_retry = 1'b0;
    logic       cfg_force_coll = 1'b0;
    logic [1:0] loop_mode = 2'b00;
    logic       frame_start = 1'b0;
    logic       coll_det = 1'b0;
    logic       tx_done = 1'b0;
    logic       attempt_go;
    logic       frame_ok;
    logic       retry_err;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_retry_ctrl #(
        .ATTEMPT_LIMIT (LIM),
        .SLOT_CYCLES   (SC),
        .BACKOFF_CAP   (CAP)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .init_load      (init_load),
        .cfg_no_retry   (cfg_no_retry),
        .cfg_force_coll (cfg_force_coll),
        .loop_mode      (loop_mode),
        .frame_start    (frame_start),
        .coll_det       (coll_det),
        .tx_done        (tx_done),
        .attempt_go     (attempt_go),
        .frame_ok       (frame_ok),
        .retry_err      (retry_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_cfg(input bit v);
        init_load = 1'b1;
        cfg_no_retry = v;
        tick();
        init_load = 1'b0;
    endtask

    task automatic start_frame(input string req);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        chk(attempt_go == 1'b1, req, "attempt strobe after start", int'(attempt_go), 1);
    endtask

    // mode 0: finish with tx_done, 1: expect retry error on last collision, 2: stop in attempt
    task automatic drive_attempts(input int ncoll, input int mode, input bit forced,
                                  input bit poke, input bit both_first, input string req);
        for (int k = 1; k <= ncoll; k++) begin
            int g;
            int slots;
            int maxs;
            bit stray;
            if (!forced) coll_det = 1'b1;
            if (both_first && k == 1) tx_done = 1'b1;
            tick();
            coll_det = 1'b0;
            tx_done = 1'b0;
            if (mode == 1 && k == ncoll) begin
                chk(retry_err == 1'b1, req, "retry error on final collision", int'(retry_err), 1);
                chk(frame_ok == 1'b0, req, "no success on final collision", int'(frame_ok), 0);
                tick();
                chk(retry_err == 1'b0, req, "retry error single cycle", int'(retry_err), 0);
                chk(attempt_go == 1'b0, req, "no attempt after error", int'(attempt_go), 0);
                return;
            end
            if (both_first && k == 1)
                chk(frame_ok == 1'b0, "R10", "collision beats done", int'(frame_ok), 0);
            if (poke && k == 1) begin
                init_load = 1'b1;
                cfg_no_retry = 1'b1;
            end
            g = 1;
            stray = frame_ok || retry_err;
            while (!attempt_go && g < 400) begin
                tick();
                init_load = 1'b0;
                g++;
                stray = stray || frame_ok || retry_err;
            end
            init_load = 1'b0;
            cfg_no_retry = 1'b0;
            chk(!stray, req, "no end pulse during backoff", int'(stray), 0);
            slots = (g - 2) / SC;
            maxs = (1 << ((k < CAP) ? k : CAP)) - 1;
            chk(g >= 2 && ((g - 2) % SC) == 0 && slots <= maxs, "R4",
                $sformatf("backoff gap after collision %0d", k), g, 2 + maxs * SC);
        end
        if (mode == 0) begin
            tx_done = 1'b1;
            tick();
            tx_done = 1'b0;
            chk(frame_ok == 1'b1, req, "success pulse", int'(frame_ok), 1);
            chk(retry_err == 1'b0, req, "no error on success", int'(retry_err), 0);
            tick();
            chk(frame_ok == 1'b0, "R3", "success single cycle", int'(frame_ok), 0);
            chk(attempt_go == 1'b0, "R3", "idle after success", int'(attempt_go), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick();
        chk(!attempt_go && !frame_ok && !retry_err, "R1", "outputs in reset",
            int'({attempt_go, frame_ok, retry_err}), 0);
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!attempt_go && !frame_ok && !retry_err, "R1", "outputs after reset",
                int'({attempt_go, frame_ok, retry_err}), 0);
        end

        // R12: stimulus while idle
        coll_det = 1'b1;
        tx_done = 1'b1;
        cfg_force_coll = 1'b1;
        loop_mode = 2'b10;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(!attempt_go && !frame_ok && !retry_err, "R12", "idle ignores inputs",
                int'({attempt_go, frame_ok, retry_err}), 0);
        end
        coll_det = 1'b0;
        tx_done = 1'b0;
        cfg_force_coll = 1'b0;
        loop_mode = 2'b00;
        tick();
        chk(!attempt_go && !frame_ok && !retry_err, "R12", "idle after release",
            int'({attempt_go, frame_ok, retry_err}), 0);

        // R2 R3 R4: sweep collision counts before success
        for (int n = 0; n < LIM; n++) begin
            start_frame("R2");
            drive_attempts(n, 0, 1'b0, 1'b0, 1'b0, "R3");
            tick();
        end

        // R5: exhaust all attempts, then block is ready again
        start_frame("R2");
        drive_attempts(LIM, 1, 1'b0, 1'b0, 1'b0, "R5");
        start_frame("R5");
        drive_attempts(1, 0, 1'b0, 1'b0, 1'b0, "R5");

        // R10: collision and done together
        start_frame("R2");
        drive_attempts(2, 0, 1'b0, 1'b0, 1'b1, "R10");

        // R6 R7: captured disable-retry
        load_cfg(1'b1);
        start_frame("R6");
        drive_attempts(1, 1, 1'b0, 1'b0, 1'b0, "R6");
        cfg_no_retry = 1'b0;
        tick();
        start_frame("R7");
        drive_attempts(1, 1, 1'b0, 1'b0, 1'b0, "R7");
        load_cfg(1'b0);
        start_frame("R7");
        drive_attempts(LIM, 1, 1'b0, 1'b1, 1'b0, "R7");
        tick();

        // R8: forced collisions in both internal loopback modes
        for (int m = 2; m < 4; m++) begin
            cfg_force_coll = 1'b1;
            loop_mode = 2'(m);
            start_frame("R8");
            drive_attempts(LIM, 1, 1'b1, 1'b0, 1'b0, "R8");
            cfg_force_coll = 1'b0;
            tick();
        end
        load_cfg(1'b1);
        cfg_force_coll = 1'b1;
        loop_mode = 2'b11;
        start_frame("R8");
        drive_attempts(1, 1, 1'b1, 1'b0, 1'b0, "R8");
        cfg_force_coll = 1'b0;
        load_cfg(1'b0);

        // R9: force outside internal loopback has no effect
        for (int m = 0; m < 2; m++) begin
            cfg_force_coll = 1'b1;
            loop_mode = 2'(m);
            start_frame("R9");
            drive_attempts(2, 0, 1'b0, 1'b0, 1'b0, "R9");
        end
        cfg_force_coll = 1'b0;
        loop_mode = 2'b00;

        // R11: restart mid-frame resets the attempt count
        start_frame("R11");
        drive_attempts(3, 2, 1'b0, 1'b0, 1'b0, "R11");
        start_frame("R11");
        drive_attempts(LIM, 1, 1'b0, 1'b0, 1'b0, "R11");

        tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule